// File: doc/BRIEF.md
# SPI Master Command-Queue Engine

This block is an SPI master whose every frame is described by one 32-bit entry taken from a transmit queue. The upper half of an entry is a command and the lower half is the data. The command picks the chip-select line and one of four attribute sets. It also says whether chip select stays asserted after the frame, whether the engine should stop after this frame, and whether the frame counter restarts. Received words are placed in a receive queue, and the receiver reads them from the head of that queue.

The engine runs whenever the transmit queue holds an entry and no end-of-queue stop is pending. Three sticky flags report progress: frame done, end of queue, and receive overflow. Each flag is cleared by a 1 on its bit of `flag_clr`. Clearing the end-of-queue flag also lets the engine continue with the next queued entry. A 16-bit counter counts completed frames. Each queue can be emptied with a one-cycle flush pulse.

Top module: `spiq_master`

## Requirements
- R1: A queue entry carries transmit data in bits 15:0 and a command in bits 31:16. The frame shifts the low N data bits out on `mosi`, most significant first unless the attribute set selects LSB-first.
- R2: Command bits 13:12 select one of four attribute bytes in `attr_cfg` (set s at bits 8s+7:8s). Within the byte, bits 3:0 hold the frame size minus one (values 0 to 2 give 4 bits), bit 4 is clock polarity, bit 5 is clock phase and bit 6 is LSB-first.
- R3: With phase 0, both sides sample on the leading `sck` edge and change data on the trailing edge. With phase 1, data changes on the leading edge and is sampled on the trailing edge. The sampled `miso` bits form a right-justified word that is pushed into the receive queue.
- R4: With LSB-first set, bit 0 of the word is shifted first and received bits are placed from bit 0 upward.
- R5: `cs_n` is active low, with one line per bit of command bits 5:0 (a one-hot mask). During a frame `cs_n` equals the inverted mask. Command bit 15 set keeps it asserted after the frame; clear releases it to all ones.
- R6: When a frame with command bit 11 completes, the engine stops and all chip selects go high. `flag_eoq` is set and queued entries wait.
- R7: Writing 1 to `flag_clr[1]` clears `flag_eoq` and lets the next queued entry start.
- R8: Every completed frame sets `flag_done` and adds one to `frame_cnt`. Command bit 10 sets the counter to zero when that frame starts.
- R9: `flag_done`, `flag_eoq` and `flag_ovf` stay set until a 1 is written to `flag_clr[2]`, `flag_clr[1]` or `flag_clr[0]` respectively.
- R10: A word received while the receive queue is full is dropped, the queue contents are kept, and `flag_ovf` is set.
- R11: A push while the transmit queue is full is ignored.
- R12: A `flush_tx` pulse empties the transmit queue, so the dropped entries never run. A `flush_rx` pulse empties the receive queue.
- R13: After reset all `cs_n` lines are high, `sck` is low, the flags and counter are zero and both queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_push | input | 1 | Write `tx_entry` into the transmit queue |
| tx_entry | input | 32 | Command (31:16) and data (15:0) |
| tx_full | output | 1 | Transmit queue full |
| tx_level | output | $clog2(QDEPTH+1) | Transmit queue occupancy |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | 16 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| rx_level | output | $clog2(QDEPTH+1) | Receive queue occupancy |
| attr_cfg | input | 32 | Four attribute bytes |
| flag_clr | input | 3 | Write-1-to-clear: [2] done, [1] end of queue, [0] overflow |
| flag_done | output | 1 | Sticky frame-done flag |
| flag_eoq | output | 1 | Sticky end-of-queue flag; engine stopped while set |
| flag_ovf | output | 1 | Sticky receive-overflow flag |
| frame_cnt | output | 16 | Completed-frame counter |
| flush_tx | input | 1 | Empty the transmit queue |
| flush_rx | input | 1 | Empty the receive queue |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 6 | Active-low chip selects |

## Verification
A wrong bit index or a wrong edge choice inside the shifter appears within one frame. It shows as a corrupted word at the slave model or at the receive queue head, and the ordering of the wrong bits points to the fault. A stuck or misdirected stop state appears as a queue level that stops falling while `flag_eoq` is low, or as frames still running while it is high. A counter fault appears in `frame_cnt` at the first frame boundary after the error. Chip-select state faults appear on `cs_n` at the next leading edge or between batches, where the bench compares the lines against the last frame's keep bit.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
    localparam int DATA_W = 16;
    localparam int CSEL_W = 6;

    typedef struct packed {
        logic              keep_cs;
        logic [2:0]        set_sel;
        logic              stop_after;
        logic              cnt_zero;
        logic [3:0]        spare;
        logic [CSEL_W-1:0] cs_mask;
    } cmd_t;

    typedef struct packed {
        cmd_t              cmd;
        logic [DATA_W-1:0] data;
    } entry_t;

    typedef struct packed {
        logic       spare;
        logic       lsb_first;
        logic       phase;
        logic       polarity;
        logic [3:0] size_m1;
    } attr_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TRAIL = 2'd2
    } eng_state_t;
endpackage

// File: rtl/spiq_fifo.sv
module spiq_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));
    assign level = q.cnt;
    assign dout  = mem[q.rd];

    always_comb begin
        d       = q;
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        if (do_push) d.wr = (q.wr == AW'(DEPTH-1)) ? '0 : q.wr + AW'(1);
        if (do_pop)  d.rd = (q.rd == AW'(DEPTH-1)) ? '0 : q.rd + AW'(1);
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + CW'(1);
            2'b01:   d.cnt = q.cnt - CW'(1);
            default: d.cnt = q.cnt;
        endcase
        if (flush) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wr] <= din;
    end
endmodule

// File: rtl/spiq_shifter.sv
module spiq_shifter
    import spiq_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ok,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [CSEL_W-1:0] ld_mask,
    input  logic [1:0]        ld_sel,
    input  logic              ld_keep,
    input  logic              ld_stop,
    input  logic              ld_zero,
    input  logic [31:0]       attr_flat,
    input  logic              miso,
    output logic              take,
    output logic              frm_start,
    output logic              frm_zero,
    output logic              frm_done,
    output logic              frm_stop,
    output logic [DATA_W-1:0] frm_rx,
    output logic              sck,
    output logic              mosi,
    output logic [CSEL_W-1:0] cs_n
);
    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        eng_state_t        st;
        logic [HW-1:0]     hc;
        logic [5:0]        ph;
        logic [3:0]        bidx;
        logic [3:0]        nm1;
        logic              phase;
        logic              lsb;
        logic              stop;
        logic              keep;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic              sck;
        logic [CSEL_W-1:0] csn;
    } eng_t;

    eng_t  q, d;
    attr_t a;
    logic  tick, lead_e, samp, shft;
    logic [5:0] np, two_n;
    logic [3:0] pos;
    logic unused_attr;

    assign unused_attr = a.spare;

    always_comb begin
        d         = q;
        take      = 1'b0;
        frm_start = 1'b0;
        frm_done  = 1'b0;
        a         = attr_t'(attr_flat[8*int'(ld_sel) +: 8]);
        tick      = (q.hc == HW'(HALF-1));
        two_n     = {1'b0, q.nm1, 1'b0} + 6'd2;
        np        = q.ph + 6'd1;
        pos       = q.lsb ? q.bidx : (q.nm1 - q.bidx);
        lead_e    = np[0];
        samp      = q.phase ? !lead_e : lead_e;
        shft      = q.phase ? (lead_e && np != 6'd1) : (!lead_e && np != two_n);
        case (q.st)
            ST_IDLE: begin
                if (start_ok) begin
                    take      = 1'b1;
                    frm_start = 1'b1;
                    d.st      = ST_SHIFT;
                    d.hc      = '0;
                    d.ph      = '0;
                    d.bidx    = '0;
                    d.nm1     = (a.size_m1 < 4'd3) ? 4'd3 : a.size_m1;
                    d.phase   = a.phase;
                    d.lsb     = a.lsb_first;
                    d.stop    = ld_stop;
                    d.keep    = ld_keep;
                    d.tx      = ld_data;
                    d.rx      = '0;
                    d.sck     = a.polarity;
                    d.csn     = ~ld_mask;
                end
            end
            ST_SHIFT: begin
                d.hc = tick ? '0 : q.hc + HW'(1);
                if (tick) begin
                    d.sck = ~q.sck;
                    if (samp) d.rx[pos] = miso;
                    if (shft) d.bidx = q.bidx + 4'd1;
                    d.ph = np;
                    if (np == two_n) d.st = ST_TRAIL;
                end
            end
            ST_TRAIL: begin
                d.hc = tick ? '0 : q.hc + HW'(1);
                if (tick) begin
                    frm_done = 1'b1;
                    d.st     = ST_IDLE;
                    if (q.stop || !q.keep) d.csn = '1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.csn <= '1;
        end else begin
            q <= d;
        end
    end

    assign frm_zero = frm_start && ld_zero;
    assign frm_stop = q.stop;
    assign frm_rx   = q.rx;
    assign sck      = q.sck;
    assign cs_n     = q.csn;
    assign mosi     = (q.st != ST_IDLE) && q.tx[pos];
endmodule

// File: rtl/spiq_master.sv
module spiq_master
    import spiq_pkg::*;
#(
    parameter int QDEPTH   = 4,
    parameter int SCK_HALF = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tx_push,
    input  logic [31:0]                 tx_entry,
    output logic                        tx_full,
    output logic [$clog2(QDEPTH+1)-1:0] tx_level,
    input  logic                        rx_pop,
    output logic [15:0]                 rx_data,
    output logic                        rx_empty,
    output logic [$clog2(QDEPTH+1)-1:0] rx_level,
    input  logic [31:0]                 attr_cfg,
    input  logic [2:0]                  flag_clr,
    output logic                        flag_done,
    output logic                        flag_eoq,
    output logic                        flag_ovf,
    output logic [15:0]                 frame_cnt,
    input  logic                        flush_tx,
    input  logic                        flush_rx,
    output logic                        sck,
    output logic                        mosi,
    input  logic                        miso,
    output logic [5:0]                  cs_n
);
    typedef struct packed {
        logic        done;
        logic        eoq;
        logic        ovf;
        logic [15:0] cnt;
    } ctl_t;

    ctl_t   q, d;
    entry_t head;
    logic [31:0] head_raw;
    logic tx_empty, rx_full;
    logic take, frm_start, frm_zero, frm_done, frm_stop;
    logic [15:0] frm_rx;
    logic unused_cmd;

    assign head       = entry_t'(head_raw);
    assign unused_cmd = ^{head.cmd.set_sel[2], head.cmd.spare};

    spiq_fifo #(.WIDTH(32), .DEPTH(QDEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush_tx),
        .push(tx_push), .din(tx_entry), .pop(take),
        .dout(head_raw), .empty(tx_empty), .full(tx_full), .level(tx_level)
    );

    spiq_fifo #(.WIDTH(16), .DEPTH(QDEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush_rx),
        .push(frm_done), .din(frm_rx), .pop(rx_pop),
        .dout(rx_data), .empty(rx_empty), .full(rx_full), .level(rx_level)
    );

    spiq_shifter #(.HALF(SCK_HALF)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .start_ok(!tx_empty && !q.eoq),
        .ld_data(head.data), .ld_mask(head.cmd.cs_mask),
        .ld_sel(head.cmd.set_sel[1:0]), .ld_keep(head.cmd.keep_cs),
        .ld_stop(head.cmd.stop_after), .ld_zero(head.cmd.cnt_zero),
        .attr_flat(attr_cfg), .miso(miso),
        .take(take), .frm_start(frm_start), .frm_zero(frm_zero),
        .frm_done(frm_done), .frm_stop(frm_stop), .frm_rx(frm_rx),
        .sck(sck), .mosi(mosi), .cs_n(cs_n)
    );

    always_comb begin
        d = q;
        if (flag_clr[2]) d.done = 1'b0;
        if (flag_clr[1]) d.eoq  = 1'b0;
        if (flag_clr[0]) d.ovf  = 1'b0;
        if (frm_start && frm_zero) d.cnt = '0;
        if (frm_done) begin
            d.cnt  = q.cnt + 16'd1;
            d.done = 1'b1;
            if (frm_stop) d.eoq = 1'b1;
            if (rx_full)  d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flag_done = q.done;
    assign flag_eoq  = q.eoq;
    assign flag_ovf  = q.ovf;
    assign frame_cnt = q.cnt;
endmodule

// File: rtl/spiq_master_chk.sv
module spiq_master_chk #(
    parameter int QDEPTH = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [5:0]                  cs_n,
    input logic                        sck,
    input logic                        flag_done,
    input logic                        flag_eoq,
    input logic                        flag_ovf,
    input logic [2:0]                  flag_clr,
    input logic [15:0]                 frame_cnt,
    input logic [$clog2(QDEPTH+1)-1:0] tx_level
);
    localparam int LW = $clog2(QDEPTH+1);

    // R5
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R6
    stop_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_eoq |-> (cs_n == 6'h3F));

    // R6
    stop_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_eoq && !flag_clr[1]) |=> $stable(sck));

    // R9
    eoq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_eoq && !flag_clr[1]) |=> flag_eoq);

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_done && !flag_clr[2]) |=> flag_done);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ovf && !flag_clr[0]) |=> flag_ovf);

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_cnt) |-> (frame_cnt == $past(frame_cnt) + 16'd1 || frame_cnt == 16'd0));

    // R11
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LW'(QDEPTH));
endmodule

bind spiq_master spiq_master_chk #(.QDEPTH(QDEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
    .flag_done(flag_done), .flag_eoq(flag_eoq), .flag_ovf(flag_ovf),
    .flag_clr(flag_clr), .frame_cnt(frame_cnt), .tx_level(tx_level)
);

// File: tb/spiq_master_tb.sv
module spiq_master_tb;
    localparam int QD = 4;
    localparam int HALF = 2;
    localparam int LW = $clog2(QD+1);

    logic clk = 0, rst_n = 0;
    logic tx_push = 0, rx_pop = 0, flush_tx = 0, flush_rx = 0, miso = 0;
    logic [31:0] tx_entry = '0, attr_cfg = '0;
    logic [2:0] flag_clr = '0;
    logic tx_full, rx_empty, flag_done, flag_eoq, flag_ovf, sck, mosi;
    logic [LW-1:0] tx_level, rx_level;
    logic [15:0] rx_data, frame_cnt;
    logic [5:0] cs_n;

    int checks = 0, errors = 0, cyc = 0;
    int exp_cnt = 0;

    logic [15:0] f_data [8];
    logic [15:0] f_miso [8];
    logic [15:0] s_mosi [8];
    logic [1:0]  f_set  [8];
    logic [5:0]  f_mask [8];
    logic        f_keep [8];
    logic        f_stop [8];
    logic        f_zero [8];

    spiq_master #(.QDEPTH(QD), .SCK_HALF(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_entry(tx_entry),
        .tx_full(tx_full), .tx_level(tx_level), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_empty(rx_empty), .rx_level(rx_level), .attr_cfg(attr_cfg),
        .flag_clr(flag_clr), .flag_done(flag_done), .flag_eoq(flag_eoq),
        .flag_ovf(flag_ovf), .frame_cnt(frame_cnt), .flush_tx(flush_tx),
        .flush_rx(flush_rx), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic int fsize(input logic [7:0] a);
        return (a[3:0] < 4'd3) ? 4 : int'(a[3:0]) + 1;
    endfunction

    function automatic int fpos(input int k, input int n, input logic lsb);
        return lsb ? k : n - 1 - k;
    endfunction

    function automatic logic [15:0] fmask(input int n);
        return 16'((32'd1 << n) - 1);
    endfunction

    function automatic logic [31:0] mk_entry(input int i);
        return {f_keep[i], 1'b0, f_set[i], f_stop[i], f_zero[i], 4'b0000, f_mask[i], f_data[i]};
    endfunction

    // slave model: follows the expected frame list edge by edge
    task automatic slave_run(input int cnt);
        for (int f = 0; f < cnt; f++) begin
            logic [7:0] a;
            logic pol, pha, lsb, lead;
            logic [15:0] got;
            int n, e;
            a = attr_cfg[8*int'(f_set[f]) +: 8];
            pol = a[4]; pha = a[5]; lsb = a[6];
            n = fsize(a);
            e = 0;
            got = '0;
            if (!pha) miso = f_miso[f][fpos(0, n, lsb)];
            while (e < 2*n) begin
                @(sck);
                if (e == 0 && sck == pol) continue;
                e++;
                lead = (e % 2 == 1);
                if (e == 1) chk(cs_n == ~f_mask[f], "R5 cs at first edge", {26'b0, cs_n}, {26'b0, ~f_mask[f]});
                if (!pha) begin
                    if (lead) got[fpos((e-1)/2, n, lsb)] = mosi;
                    else if (e < 2*n) miso = f_miso[f][fpos(e/2, n, lsb)];
                end else begin
                    if (lead) miso = f_miso[f][fpos((e-1)/2, n, lsb)];
                    else got[fpos(e/2-1, n, lsb)] = mosi;
                end
            end
            s_mosi[f] = got;
        end
    endtask

    task automatic push_entry(input logic [31:0] e);
        @(negedge clk);
        while (tx_full) @(negedge clk);
        tx_push = 1; tx_entry = e;
        @(negedge clk);
        tx_push = 0;
    endtask

    task automatic pop_word(output logic [15:0] w);
        @(negedge clk);
        w = rx_data;
        rx_pop = 1;
        @(negedge clk);
        rx_pop = 0;
    endtask

    task automatic pulse_clr(input logic [2:0] m);
        @(negedge clk);
        flag_clr = m;
        @(negedge clk);
        flag_clr = '0;
    endtask

    task automatic model_count(input int cnt);
        for (int i = 0; i < cnt; i++) begin
            if (f_zero[i]) exp_cnt = 0;
            exp_cnt = (exp_cnt + 1) & 16'hFFFF;
        end
    endtask

    task automatic run_frames(input int cnt);
        fork
            slave_run(cnt);
            for (int i = 0; i < cnt; i++) push_entry(mk_entry(i));
        join
        repeat (4*HALF + 10) @(posedge clk);
        model_count(cnt);
    endtask

    task automatic check_batch(input int cnt);
        logic [15:0] w;
        int n;
        for (int i = 0; i < cnt; i++) begin
            n = fsize(attr_cfg[8*int'(f_set[i]) +: 8]);
            chk(s_mosi[i] == (f_data[i] & fmask(n)), "R1 R3 R4 mosi word", {16'b0, s_mosi[i]}, {16'b0, f_data[i] & fmask(n)});
            pop_word(w);
            chk(w == (f_miso[i] & fmask(n)), "R3 R4 rx word", {16'b0, w}, {16'b0, f_miso[i] & fmask(n)});
        end
        chk(frame_cnt == 16'(exp_cnt), "R8 frame counter", {16'b0, frame_cnt}, exp_cnt);
        chk(flag_done == 1'b1, "R8 done flag", {31'b0, flag_done}, 1);
        if (f_keep[cnt-1])
            chk(cs_n == ~f_mask[cnt-1], "R5 cs kept", {26'b0, cs_n}, {26'b0, ~f_mask[cnt-1]});
        else
            chk(cs_n == 6'h3F, "R5 cs released", {26'b0, cs_n}, 32'h3F);
        pulse_clr(3'b100);
        chk(flag_done == 1'b0, "R9 done cleared", {31'b0, flag_done}, 0);
    endtask

    task automatic rand_frame(input int i);
        f_data[i] = 16'($urandom);
        f_miso[i] = 16'($urandom);
        f_set[i]  = 2'($urandom % 4);
        f_mask[i] = 6'(1 << ($urandom % 6));
        f_keep[i] = 1'($urandom % 2);
        f_stop[i] = 1'b0;
        f_zero[i] = ($urandom % 5 == 0);
    endtask

    initial begin
        logic [15:0] w;
        void'($urandom(32'h1234_5eed));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R13 reset state
        chk(cs_n == 6'h3F, "R13 cs", {26'b0, cs_n}, 32'h3F);
        chk(sck == 1'b0 && flag_done == 0 && flag_eoq == 0 && flag_ovf == 0, "R13 flags sck",
            {28'b0, sck, flag_done, flag_eoq, flag_ovf}, 0);
        chk(frame_cnt == 0 && tx_level == 0 && rx_empty == 1, "R13 queues counter",
            {frame_cnt, 8'b0, 7'(tx_level), rx_empty}, 1);

        // directed: mode 0, 8 bits, MSB first (R1)
        attr_cfg = {8'h47, 8'h6B, 8'h3F, 8'h07};
        f_data[0] = 16'h00A5; f_miso[0] = 16'h003C; f_set[0] = 0; f_mask[0] = 6'h01;
        f_keep[0] = 0; f_stop[0] = 0; f_zero[0] = 1;
        run_frames(1);
        check_batch(1);

        // directed: size field below 3 gives 4 bits (R2)
        attr_cfg[7:0] = 8'h21;
        f_data[0] = 16'hFFF9; f_miso[0] = 16'hBEE6; f_mask[0] = 6'h20; f_zero[0] = 0;
        f_data[1] = 16'h1234; f_miso[1] = 16'h8001; f_set[1] = 1; f_mask[1] = 6'h04;
        f_keep[1] = 1; f_stop[1] = 0; f_zero[1] = 0;
        run_frames(2);
        check_batch(2);

        // random batches across all modes and orders (R1 R2 R3 R4 R5 R8)
        for (int b = 0; b < 14; b++) begin
            int cnt;
            attr_cfg = $urandom;
            cnt = 1 + int'($urandom % 4);
            for (int i = 0; i < cnt; i++) rand_frame(i);
            run_frames(cnt);
            check_batch(cnt);
        end

        // R6 R7: stop after first frame, second waits
        attr_cfg = {8'h1F, 8'h5F, 8'h3B, 8'h0F};
        rand_frame(0); rand_frame(1);
        f_stop[0] = 1; f_keep[0] = 1; f_zero[0] = 0; f_zero[1] = 0; f_keep[1] = 0;
        fork slave_run(2); join_none
        push_entry(mk_entry(0));
        push_entry(mk_entry(1));
        for (int t = 0; t < 2000 && !flag_eoq; t++) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(flag_eoq == 1'b1, "R6 eoq flag", {31'b0, flag_eoq}, 1);
        chk(cs_n == 6'h3F, "R6 cs forced high", {26'b0, cs_n}, 32'h3F);
        chk(tx_level == LW'(1), "R6 entry waits", {29'b0, 3'(tx_level)}, 1);
        chk(frame_cnt == 16'(exp_cnt + 1), "R6 one frame only", {16'b0, frame_cnt}, exp_cnt + 1);
        pulse_clr(3'b010);
        chk(flag_eoq == 1'b0, "R7 eoq cleared", {31'b0, flag_eoq}, 0);
        wait fork;
        repeat (4*HALF + 10) @(posedge clk);
        model_count(2);
        check_batch(2);

        // R11 R12: fill while stopped, then flush
        rand_frame(0); f_stop[0] = 1; f_zero[0] = 0;
        run_frames(1);
        pop_word(w);
        chk(flag_eoq == 1'b1, "R6 stopped again", {31'b0, flag_eoq}, 1);
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            tx_push = 1; tx_entry = 32'h0001_0000 | i;
            @(negedge clk);
        end
        tx_push = 0;
        chk(tx_level == LW'(QD), "R11 push when full ignored", {29'b0, 3'(tx_level)}, QD);
        @(negedge clk); flush_tx = 1; @(negedge clk); flush_tx = 0;
        chk(tx_level == 0, "R12 tx flush", {29'b0, 3'(tx_level)}, 0);
        pulse_clr(3'b010);
        repeat (200) @(negedge clk);
        chk(frame_cnt == 16'(exp_cnt), "R12 flushed entries never run", {16'b0, frame_cnt}, exp_cnt);
        chk(cs_n == 6'h3F, "R12 cs idle after flush", {26'b0, cs_n}, 32'h3F);
        pulse_clr(3'b100);

        // R10 overflow: five frames into a four-deep receive queue
        for (int i = 0; i < 5; i++) rand_frame(i);
        run_frames(5);
        chk(flag_ovf == 1'b1, "R10 overflow flag", {31'b0, flag_ovf}, 1);
        chk(rx_level == LW'(QD), "R10 rx level", {29'b0, 3'(rx_level)}, QD);
        for (int i = 0; i < 4; i++) begin
            int n;
            n = fsize(attr_cfg[8*int'(f_set[i]) +: 8]);
            pop_word(w);
            chk(w == (f_miso[i] & fmask(n)), "R10 kept words", {16'b0, w}, {16'b0, f_miso[i] & fmask(n)});
        end
        chk(rx_empty == 1'b1, "R10 fifth word dropped", {31'b0, rx_empty}, 1);
        pulse_clr(3'b001);
        chk(flag_ovf == 1'b0, "R9 ovf cleared", {31'b0, flag_ovf}, 0);

        // R12 receive flush
        rand_frame(0); rand_frame(1);
        run_frames(2);
        chk(rx_level == LW'(2), "R12 rx before flush", {29'b0, 3'(rx_level)}, 2);
        @(negedge clk); flush_rx = 1; @(negedge clk); flush_rx = 0;
        chk(rx_empty == 1'b1, "R12 rx flush", {31'b0, rx_empty}, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule